// File: doc/BRIEF.md
# Scatter-Gather Upstream Write DMA

This engine carries a user data stream into host memory. The stream is presented as a first-word-fall-through source (valid, data, last, with ready back from the engine). Software starts a transfer by giving an upper bound on its length in data words. It then points the engine at a shared buffer of scatter-gather elements by giving the buffer's byte address and the number of elements it holds. The engine reads one element at a time over a simple read-request/completion bus. It then streams words out as memory write beats into the region that element describes. A write request is cut short at the programmed payload limit, at a 4 KB page edge, at the end of the element, and at the end of the transfer.

The elements only bound the transfer. The user may close the stream early with its last flag. If the elements run out while data is still expected, the engine pulses its interrupt with a refill cause and waits for a fresh buffer. When the transfer ends, it pulses the interrupt with a completion cause. The number of words actually written stays readable on `final_count` until the next start. The data width is a parameter, meant to be set to 32, 64 or 128 bits.

Top module: `sgdma_up`

## Requirements
- R1: After reset, `irq` is 0, `irq_stat` is 0, `s_ready` is 0, `rdreq_valid` is 0 and `final_count` is 0.
- R2: Each element is fetched with its own read request. The first request goes to the programmed buffer address, and each later one is 12 bytes beyond the previous. A completion carries the element address in `cpl_data[63:0]` and its word length in `cpl_data[95:64]`.
- R3: Stream words go out in order as write beats. The address starts at the element address and steps by DATA_W/8 bytes per beat. `wr_first` marks the opening beat of a request and `wr_last` its closing beat.
- R4: No write request holds more than `max_payload` beats.
- R5: A beat that writes the last word of a 4 KB page always carries `wr_last`, so no request crosses a page edge.
- R6: An element whose length is 0 produces no write beat, and the engine goes on to fetch the next element.
- R7: When the elements are used up and the transfer is not over, the engine pulses `irq` with `irq_stat` bit 0 set. It then accepts no stream data until a new buffer is given with `sgl_valid`.
- R8: The transfer ends at the first beat that either carries `s_last` or reaches the declared length. That beat carries `wr_last`, and `irq` then pulses with `irq_stat` bit 1 set.
- R9: After completion, `final_count` equals the number of words written, which may be less than the sum of element lengths.
- R10: `irq` is high for exactly one cycle per event. A cycle with `stat_rd` high clears `irq_stat` at the next edge. If an event is recorded in the same cycle as a read, the event's bit is set after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Pulse: begin a transfer |
| xfer_len | input | LEN_W | Transfer length bound in words, sampled with `xfer_start` |
| sgl_valid | input | 1 | Pulse: element buffer location is valid |
| sgl_addr | input | ADDR_W | Byte address of the element buffer |
| sgl_count | input | LEN_W | Number of elements in the buffer |
| max_payload | input | PAY_W | Largest write request, in beats |
| s_valid | input | 1 | Stream word present |
| s_data | input | DATA_W | Stream word |
| s_last | input | 1 | Stream word is the final one |
| s_ready | output | 1 | Engine takes the stream word |
| rdreq_valid | output | 1 | Element read request |
| rdreq_addr | output | ADDR_W | Byte address of the element to read |
| rdreq_ready | input | 1 | Read request accepted |
| cpl_valid | input | 1 | Element completion present |
| cpl_data | input | ADDR_W+LEN_W | Element: address low, length high |
| wr_valid | output | 1 | Write beat present |
| wr_ready | input | 1 | Write beat accepted |
| wr_addr | output | ADDR_W | Byte address of this beat |
| wr_data | output | DATA_W | Data of this beat |
| wr_first | output | 1 | Opening beat of a write request |
| wr_last | output | 1 | Closing beat of a write request |
| irq | output | 1 | One-cycle interrupt pulse |
| irq_stat | output | 2 | Cause: bit 0 refill, bit 1 done |
| stat_rd | input | 1 | Status read, clears `irq_stat` |
| final_count | output | LEN_W | Words written in the current or last transfer |

## Verification
Two things can meet in one cycle. One is the status register's read-clear and a new completion event setting its bit. The other is the stream's last flag on the same beat that reaches the declared length. Both are provoked by holding `stat_rd` high through a whole transfer whose final beat carries `s_last` at exactly the declared length. The outcome is judged by seeing exactly one `irq`, `irq_stat` still showing completion once the read is dropped, and a single closing `wr_last`.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_WAIT_SGL   = 3'd1,
        ST_FETCH_REQ  = 3'd2,
        ST_FETCH_WAIT = 3'd3,
        ST_MOVE       = 3'd4,
        ST_REFILL     = 3'd5,
        ST_DONE       = 3'd6
    } sg_state_e;

    localparam int unsigned ELEM_BYTES = 12;
    localparam int unsigned PAGE_BYTES = 4096;

endpackage

// File: rtl/sgdma_burst_cut.sv
module sgdma_burst_cut #(
    parameter int unsigned BYTES = 8,
    parameter int unsigned PAY_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic [11:0]      page_off,
    input  logic [PAY_W-1:0] max_words,
    input  logic             force_end,
    output logic             first,
    output logic             last
);
    import sgdma_pkg::*;

    localparam logic [11:0] PG_LAST = 12'(PAGE_BYTES - BYTES);

    typedef struct packed {
        logic [PAY_W-1:0] cnt;
    } cut_t;

    cut_t c_d, c_q;
    logic page_end;
    logic cap_hit;

    always_comb begin
        c_d      = c_q;
        page_end = (page_off == PG_LAST);
        cap_hit  = ((c_q.cnt + PAY_W'(1)) >= max_words);
        first    = (c_q.cnt == '0);
        last     = force_end | page_end | cap_hit;
        if (beat) begin
            c_d.cnt = last ? '0 : c_q.cnt + PAY_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    // R3: a closed request is followed by an opening beat
    a_r3_first_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && last) |=> first);

    // R4: the beat counter never runs past the cap while a request is open
    a_r4_cap_open: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !last && max_words != '0) |=> (c_q.cnt < max_words));

endmodule

// File: rtl/sgdma_irq_stat.sv
module sgdma_irq_stat (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_refill,
    input  logic       ev_done,
    input  logic       rd,
    output logic       irq,
    output logic [1:0] stat
);
    typedef struct packed {
        logic       irq;
        logic [1:0] stat;
    } irq_t;

    irq_t i_d, i_q;

    always_comb begin
        i_d      = i_q;
        i_d.irq  = ev_refill | ev_done;
        i_d.stat = (i_q.stat & ~{2{rd}}) | {ev_done, ev_refill};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_q <= '0;
        end else begin
            i_q <= i_d;
        end
    end

    assign irq  = i_q.irq;
    assign stat = i_q.stat;

    // R10: interrupt is a single-cycle pulse
    a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R10: a pulse always has a recorded cause
    a_r10_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat != 2'b00));

    // R10: an event beats a simultaneous read-clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (ev_refill || ev_done)) |=> (stat != 2'b00));

endmodule

// File: rtl/sgdma_up.sv
module sgdma_up #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned LEN_W  = 32,
    parameter int unsigned PAY_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    xfer_start,
    input  logic [LEN_W-1:0]        xfer_len,
    input  logic                    sgl_valid,
    input  logic [ADDR_W-1:0]       sgl_addr,
    input  logic [LEN_W-1:0]        sgl_count,
    input  logic [PAY_W-1:0]        max_payload,
    input  logic                    s_valid,
    input  logic [DATA_W-1:0]       s_data,
    input  logic                    s_last,
    output logic                    s_ready,
    output logic                    rdreq_valid,
    output logic [ADDR_W-1:0]       rdreq_addr,
    input  logic                    rdreq_ready,
    input  logic                    cpl_valid,
    input  logic [ADDR_W+LEN_W-1:0] cpl_data,
    output logic                    wr_valid,
    input  logic                    wr_ready,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic [DATA_W-1:0]       wr_data,
    output logic                    wr_first,
    output logic                    wr_last,
    output logic                    irq,
    output logic [1:0]              irq_stat,
    input  logic                    stat_rd,
    output logic [LEN_W-1:0]        final_count
);
    import sgdma_pkg::*;

    localparam int unsigned BYTES   = DATA_W / 8;
    localparam logic [11:0] PG_LAST = 12'(PAGE_BYTES - BYTES);

    typedef struct packed {
        sg_state_e         st;
        logic [ADDR_W-1:0] buf_ptr;
        logic [LEN_W-1:0]  elems_left;
        logic [ADDR_W-1:0] dst;
        logic [LEN_W-1:0]  elem_rem;
        logic [LEN_W-1:0]  total_rem;
        logic [LEN_W-1:0]  count;
    } regs_t;

    regs_t r_d, r_q;

    logic              fire;
    logic              end_xfer;
    logic              elem_end;
    logic              ev_refill;
    logic              ev_done;
    logic [ADDR_W-1:0] cpl_addr;
    logic [LEN_W-1:0]  cpl_len;

    assign cpl_addr = cpl_data[ADDR_W-1:0];
    assign cpl_len  = cpl_data[ADDR_W +: LEN_W];

    assign s_ready     = (r_q.st == ST_MOVE) && wr_ready;
    assign wr_valid    = (r_q.st == ST_MOVE) && s_valid;
    assign wr_data     = s_data;
    assign wr_addr     = r_q.dst;
    assign fire        = wr_valid && wr_ready;
    assign rdreq_valid = (r_q.st == ST_FETCH_REQ) && (r_q.elems_left != '0);
    assign rdreq_addr  = r_q.buf_ptr;
    assign final_count = r_q.count;

    assign end_xfer = s_last || (r_q.total_rem == LEN_W'(1));
    assign elem_end = (r_q.elem_rem == LEN_W'(1));

    always_comb begin
        r_d       = r_q;
        ev_refill = 1'b0;
        ev_done   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (xfer_start) begin
                    r_d.total_rem = xfer_len;
                    r_d.count     = '0;
                    r_d.st        = (xfer_len == '0) ? ST_DONE : ST_WAIT_SGL;
                end
            end
            ST_WAIT_SGL: begin
                if (sgl_valid) begin
                    r_d.buf_ptr    = sgl_addr;
                    r_d.elems_left = sgl_count;
                    r_d.st         = ST_FETCH_REQ;
                end
            end
            ST_FETCH_REQ: begin
                if (r_q.elems_left == '0) begin
                    r_d.st = ST_REFILL;
                end else if (rdreq_ready) begin
                    r_d.st = ST_FETCH_WAIT;
                end
            end
            ST_FETCH_WAIT: begin
                if (cpl_valid) begin
                    r_d.buf_ptr    = r_q.buf_ptr + ADDR_W'(ELEM_BYTES);
                    r_d.elems_left = r_q.elems_left - LEN_W'(1);
                    r_d.dst        = cpl_addr;
                    r_d.elem_rem   = cpl_len;
                    r_d.st         = (cpl_len == '0) ? ST_FETCH_REQ : ST_MOVE;
                end
            end
            ST_MOVE: begin
                if (fire) begin
                    r_d.dst       = r_q.dst + ADDR_W'(BYTES);
                    r_d.elem_rem  = r_q.elem_rem - LEN_W'(1);
                    r_d.total_rem = r_q.total_rem - LEN_W'(1);
                    r_d.count     = r_q.count + LEN_W'(1);
                    if (end_xfer) begin
                        r_d.st = ST_DONE;
                    end else if (elem_end) begin
                        r_d.st = ST_FETCH_REQ;
                    end
                end
            end
            ST_REFILL: begin
                ev_refill = 1'b1;
                r_d.st    = ST_WAIT_SGL;
            end
            ST_DONE: begin
                ev_done = 1'b1;
                r_d.st  = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    sgdma_burst_cut #(
        .BYTES (BYTES),
        .PAY_W (PAY_W)
    ) u_cut (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat      (fire),
        .page_off  (r_q.dst[11:0]),
        .max_words (max_payload),
        .force_end (end_xfer || elem_end),
        .first     (wr_first),
        .last      (wr_last)
    );

    sgdma_irq_stat u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_refill (ev_refill),
        .ev_done   (ev_done),
        .rd        (stat_rd),
        .irq       (irq),
        .stat      (irq_stat)
    );

    // R5: the beat on a page's final word closes its request
    a_r5_page_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && wr_addr[11:0] == PG_LAST) |-> wr_last);

    // R2: a pending element read holds its address
    a_r2_rdreq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rdreq_valid && !rdreq_ready) |=> (rdreq_valid && $stable(rdreq_addr)));

    // R8: a beat carrying the stream's last flag closes its request
    a_r8_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && s_last) |-> wr_last);

    // R7: no stream data is taken while a new buffer is awaited
    a_r7_stall_on_refill: assert property (@(posedge clk) disable iff (!rst_n)
        irq && irq_stat[0] |-> !s_ready);

endmodule

// File: tb/sgdma_up_tb.sv
module sgdma_up_tb;
    localparam int DATA_W = 64;
    localparam int ADDR_W = 64;
    localparam int LEN_W  = 32;
    localparam int PAY_W  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic                    xfer_start = 0, sgl_valid = 0, stat_rd = 0;
    logic [LEN_W-1:0]        xfer_len = 0, sgl_count = 0;
    logic [ADDR_W-1:0]       sgl_addr = 0;
    logic [PAY_W-1:0]        max_payload = 16;
    logic                    s_valid, s_last, s_ready;
    logic [DATA_W-1:0]       s_data;
    logic                    rdreq_valid, rdreq_ready;
    logic [ADDR_W-1:0]       rdreq_addr;
    logic                    cpl_valid;
    logic [ADDR_W+LEN_W-1:0] cpl_data;
    logic                    wr_valid, wr_ready, wr_first, wr_last;
    logic [ADDR_W-1:0]       wr_addr;
    logic [DATA_W-1:0]       wr_data;
    logic                    irq;
    logic [1:0]              irq_stat;
    logic [LEN_W-1:0]        final_count;

    sgdma_up u_dut (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_len(xfer_len),
        .sgl_valid(sgl_valid), .sgl_addr(sgl_addr), .sgl_count(sgl_count),
        .max_payload(max_payload), .s_valid(s_valid), .s_data(s_data),
        .s_last(s_last), .s_ready(s_ready), .rdreq_valid(rdreq_valid),
        .rdreq_addr(rdreq_addr), .rdreq_ready(rdreq_ready), .cpl_valid(cpl_valid),
        .cpl_data(cpl_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_first(wr_first),
        .wr_last(wr_last), .irq(irq), .irq_stat(irq_stat), .stat_rd(stat_rd),
        .final_count(final_count)
    );

    int nchk = 0, nfail = 0;

    // Stimulus and record state
    logic                    src_en = 0, src_fire = 0, bp_en = 0;
    longint                  seq = 100, start_seq = 100;
    int                      src_sent = 0, last_at = 0;
    logic [ADDR_W-1:0]       b_addr [0:255];
    logic [DATA_W-1:0]       b_data [0:255];
    logic                    b_first [0:255];
    logic                    b_last [0:255];
    int                      nbeats = 0;
    logic [ADDR_W-1:0]       rd_addrs [0:15];
    int                      nrd = 0;
    int                      nirq = 0;
    logic [1:0]              stat_at_irq = 0;
    logic [ADDR_W+LEN_W-1:0] elem_tab [0:7];
    int                      pend = 0, pidx = 0, cyc = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // stream source
    initial begin
        s_valid = 0; s_data = 0; s_last = 0;
        forever begin
            @(negedge clk);
            if (src_fire) begin seq++; src_sent++; end
            s_valid = src_en;
            s_data  = DATA_W'(seq);
            s_last  = (last_at != 0) && (src_sent + 1 == last_at);
            #1;
            src_fire = s_valid && s_ready;
        end
    end

    // write sink
    initial begin
        wr_ready = 0;
        forever begin
            @(negedge clk);
            cyc++;
            wr_ready = bp_en ? (cyc % 3 != 0) : 1'b1;
            #1;
            if (wr_valid && wr_ready && nbeats < 256) begin
                b_addr[nbeats]  = wr_addr;
                b_data[nbeats]  = wr_data;
                b_first[nbeats] = wr_first;
                b_last[nbeats]  = wr_last;
                nbeats++;
            end
        end
    end

    // element memory responder
    initial begin
        rdreq_ready = 0; cpl_valid = 0; cpl_data = 0;
        forever begin
            @(negedge clk);
            rdreq_ready = 1'b1;
            cpl_valid   = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    cpl_valid = 1'b1;
                    cpl_data  = elem_tab[pidx];
                end
            end
            #1;
            if (rdreq_valid && rdreq_ready && pend == 0 && !cpl_valid) begin
                if (nrd < 16) rd_addrs[nrd] = rdreq_addr;
                nrd++;
                pidx = int'((rdreq_addr - 64'h1000) / 12) & 7;
                pend = 3;
            end
        end
    end

    // interrupt monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (irq) begin
                nirq++;
                stat_at_irq = irq_stat;
            end
        end
    end

    // watchdog
    initial begin
        #(5ns * 150000);
        nfail++;
        nchk++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    function automatic logic [95:0] elem(input logic [63:0] a, input logic [31:0] n);
        return {n, a};
    endfunction

    task automatic setup(input int l_at, input bit bp, input int maxp);
        @(negedge clk); #2;
        nbeats = 0; nrd = 0; nirq = 0; src_sent = 0;
        start_seq = seq; last_at = l_at; bp_en = bp;
        max_payload = PAY_W'(maxp); src_en = 1'b1;
    endtask

    task automatic start_xfer(input int len, input logic [63:0] ba, input int cnt);
        @(negedge clk);
        xfer_start = 1'b1; xfer_len = LEN_W'(len);
        @(negedge clk);
        xfer_start = 1'b0;
        sgl_valid = 1'b1; sgl_addr = ba; sgl_count = LEN_W'(cnt);
        @(negedge clk);
        sgl_valid = 1'b0;
    endtask

    task automatic send_sgl(input logic [63:0] ba, input int cnt);
        @(negedge clk);
        sgl_valid = 1'b1; sgl_addr = ba; sgl_count = LEN_W'(cnt);
        @(negedge clk);
        sgl_valid = 1'b0;
    endtask

    task automatic wait_irq(input int target, input string req);
        int n = 0;
        while (nirq < target && n < 3000) begin
            @(negedge clk); #2;
            n++;
        end
        check(nirq >= target, req, "irq seen", 64'(nirq), 64'(target));
    endtask

    task automatic read_stat();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
        #2;
    endtask

    task automatic t_reset();
        check(irq == 0, "R1", "irq", 64'(irq), 0);
        check(irq_stat == 0, "R1", "irq_stat", 64'(irq_stat), 0);
        check(s_ready == 0 && rdreq_valid == 0, "R1", "ready/req",
              64'({s_ready, rdreq_valid}), 0);
        check(final_count == 0, "R1", "final_count", 64'(final_count), 0);
    endtask

    // R3/R4: one element split by payload cap, with write backpressure
    task automatic t_payload_split();
        int bad_a = 0, bad_d = 0, bad_f = 0;
        elem_tab[0] = elem(64'h20000, 8);
        setup(0, 1'b1, 4);
        start_xfer(8, 64'h1000, 1);
        wait_irq(1, "R8");
        check(nbeats == 8, "R3", "beats", 64'(nbeats), 8);
        for (int i = 0; i < 8; i++) begin
            if (b_addr[i] != 64'h20000 + 64'(8 * i)) bad_a++;
            if (b_data[i] != 64'(start_seq + i)) bad_d++;
            if (b_first[i] != (i % 4 == 0) || b_last[i] != (i % 4 == 3)) bad_f++;
        end
        check(bad_a == 0, "R3", "address mismatches", 64'(bad_a), 0);
        check(bad_d == 0, "R3", "data mismatches", 64'(bad_d), 0);
        check(bad_f == 0, "R4", "request framing mismatches", 64'(bad_f), 0);
        check(stat_at_irq == 2'b10, "R8", "stat at done", 64'(stat_at_irq), 2);
        check(final_count == 8, "R9", "count", 64'(final_count), 8);
        check(rd_addrs[0] == 64'h1000, "R2", "first element read", rd_addrs[0], 64'h1000);
        read_stat();
        check(irq_stat == 0, "R10", "stat after read", 64'(irq_stat), 0);
    endtask

    // R5: element crosses a 4 KB page
    task automatic t_page_cross();
        elem_tab[0] = elem(64'h1FF0, 6);
        setup(0, 1'b0, 16);
        start_xfer(6, 64'h1000, 1);
        wait_irq(1, "R8");
        check(nbeats == 6, "R5", "beats", 64'(nbeats), 6);
        check(b_last[1] == 1 && b_addr[1] == 64'h1FF8, "R5", "page edge close",
              64'({b_last[1], b_addr[1][15:0]}), 64'h1_1FF8);
        check(b_first[2] == 1 && b_addr[2] == 64'h2000, "R5", "reopen at page",
              64'({b_first[2], b_addr[2][15:0]}), 64'h1_2000);
        check(b_last[5] == 1, "R3", "element end close", 64'(b_last[5]), 1);
        read_stat();
    endtask

    // R8/R9: stream ends early by its last flag
    task automatic t_early_last();
        elem_tab[0] = elem(64'h30000, 100);
        setup(5, 1'b0, 16);
        start_xfer(100, 64'h1000, 1);
        wait_irq(1, "R8");
        check(nbeats == 5, "R8", "beats", 64'(nbeats), 5);
        check(b_last[4] == 1, "R8", "flush close", 64'(b_last[4]), 1);
        check(final_count == 5, "R9", "count below bound", 64'(final_count), 5);
        check(stat_at_irq == 2'b10, "R8", "stat", 64'(stat_at_irq), 2);
        read_stat();
    endtask

    // R7: refill request mid-transfer
    task automatic t_refill();
        elem_tab[0] = elem(64'h40000, 3);
        elem_tab[1] = elem(64'h50000, 4);
        setup(0, 1'b0, 16);
        start_xfer(5, 64'h1000, 1);
        wait_irq(1, "R7");
        check(stat_at_irq == 2'b01, "R7", "refill cause", 64'(stat_at_irq), 1);
        repeat (5) @(negedge clk);
        check(nbeats == 3, "R7", "stall beats", 64'(nbeats), 3);
        read_stat();
        check(irq_stat == 0, "R10", "refill cleared", 64'(irq_stat), 0);
        send_sgl(64'h100C, 1);
        wait_irq(2, "R8");
        check(nbeats == 5, "R7", "beats", 64'(nbeats), 5);
        check(b_addr[3] == 64'h50000 && b_first[3], "R7", "new element start",
              b_addr[3], 64'h50000);
        check(rd_addrs[1] == 64'h100C, "R2", "refill read address", rd_addrs[1], 64'h100C);
        check(final_count == 5, "R9", "count", 64'(final_count), 5);
        read_stat();
    endtask

    // R6: zero-length element skipped
    task automatic t_zero_elem();
        elem_tab[0] = elem(64'h60000, 0);
        elem_tab[1] = elem(64'h70000, 3);
        setup(0, 1'b0, 16);
        start_xfer(3, 64'h1000, 2);
        wait_irq(1, "R8");
        check(nbeats == 3, "R6", "beats", 64'(nbeats), 3);
        check(b_addr[0] == 64'h70000, "R6", "first beat address", b_addr[0], 64'h70000);
        check(nrd == 2 && rd_addrs[1] == 64'h100C, "R2", "second element read",
              rd_addrs[1], 64'h100C);
        check(nirq == 1 && stat_at_irq == 2'b10, "R6", "no refill", 64'(stat_at_irq), 2);
        read_stat();
    endtask

    // R10/R8: read held during completion; last flag meets length
    task automatic t_collide();
        elem_tab[0] = elem(64'h80000, 10);
        setup(3, 1'b0, 16);
        @(negedge clk); stat_rd = 1'b1;
        start_xfer(3, 64'h1000, 1);
        wait_irq(1, "R10");
        stat_rd = 1'b0;
        check(stat_at_irq == 2'b10, "R10", "set beats clear", 64'(stat_at_irq), 2);
        @(negedge clk); #2;
        check(irq_stat == 2'b10, "R10", "stat kept", 64'(irq_stat), 2);
        check(nirq == 1 && irq == 0, "R10", "single pulse", 64'(nirq), 1);
        check(nbeats == 3 && b_last[2], "R8", "one close", 64'(nbeats), 3);
        check(final_count == 3, "R9", "count", 64'(final_count), 3);
        read_stat();
        check(irq_stat == 0, "R10", "cleared", 64'(irq_stat), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        t_reset();
        t_payload_split();
        t_page_cross();
        t_early_last();
        t_refill();
        t_zero_elem();
        t_collide();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule